// File: doc/BRIEF.md
# Rate-Trim Second Generator with Test Output

This block turns a stream of oscillator-rate enables (nominally 32,768 per second) into a corrected one-second pulse. It counts in two stages. The low stage divides by 256. The high stage counts low-stage periods up to one second. To trim a crystal that runs fast or slow, the block modifies the first second of selected minutes. A positive setting drops one whole low-stage period from that second, so the clock speeds up by 256 oscillator cycles. A negative setting stretches the first low-stage period of that second by 128 cycles, so the clock slows down. These are the same amounts in ppm as one step of the 64-minute correction scheme (+512 or −256 cycles per cycle for each step). Both amounts are parameters.

A 6-bit position counter tracks the minute within a 64-minute correction cycle. It advances on a minute tick that comes from the external calendar counters. With a magnitude of N, the first 2N minutes of the cycle are corrected, and minutes 62 and 63 never are. A clear input, raised whenever the time registers are written, restarts the divider. It also sets the position so that the next minute tick opens minute 0.

The same control byte drives one open-drain pin. With the test bit set, the pin carries a 512 Hz square wave from its own counter, so calibration never changes it. With the test bit clear, the pin shows a static level bit.

Top module: `rtrim_unit`

## Requirements
- R1: `sec_tick` is a one-cycle pulse and is never high in two consecutive cycles. An unmodified second lasts 2^(LO_W+HI_W) counted enables (32768 by default).
- R2: In a cycle where `osc_en` is 0 or `stop` is 1, nothing is counted. `sec_tick` is 0 in the following cycle, and a toggling test output holds its level.
- R3: When sign bit `cal[5]` is 1, a modified second ends DROP_PER low-stage periods early. By default it is 256 enables shorter.
- R4: When `cal[5]` is 0, a modified second has its first low-stage period stretched by EXTRA_CYC enables. By default it is 128 enables longer.
- R5: With magnitude N = `cal[4:0]`, minutes 0 to 2N−1 of the cycle are modified and all other minutes are not. N = 0 disables correction.
- R6: Only the first second after a `minute_tick` is modified. The minute position advances once per tick and wraps from 63 to 0.
- R7: A `clr` pulse restarts the divider, so the next full second is unmodified. The next `minute_tick` then opens minute 0. `sec_tick` is 0 in the cycle after `clr`.
- R8: When `cal[6]` is 1, `pin_low` changes level every 32 counted enables (512 Hz). This spacing does not depend on `cal[5:0]` and is not disturbed by `clr`.
- R9: When `cal[6]` is 0, `pin_low` equals the inverse of `cal[7]`. The pin is pulled low when the level bit is 0.
- R10: After reset the divider and the test toggle start at zero, so `pin_low` is 1 with `cal[6]` set. `sec_tick` is 0, and the cycle position matches the position after `clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| stop | input | 1 | Oscillator halt; freezes all counting |
| clr | input | 1 | Restart divider and correction cycle (time-register write) |
| minute_tick | input | 1 | Start of a new minute from the calendar counters |
| cal | input | 8 | Control byte: [7] pin level, [6] test enable, [5] sign, [4:0] magnitude |
| sec_tick | output | 1 | Corrected one-second pulse |
| pin_low | output | 1 | Open-drain enable: 1 pulls the pin low |

## Verification
The wrap of the 64-minute cycle is the hardest point to reach, because it only occurs after 64 minute ticks. The bench shrinks the high stage to 4 periods, which makes a second 1024 enables long. It also issues a minute tick right after every second. With magnitude 31, a 66-minute run then shows corrected minutes 0–61, then two plain minutes, then corrected minutes 0 and 1 again. Measured second lengths (768, 1024, 1152) show both where the correction falls and which way it goes.

// File: rtl/rtrim_pkg.sv
// Shared types for the rate-trim block.
package rtrim_pkg;
    // Control byte layout: bit positions are decoded by the block.
    typedef struct packed {
        logic       lvl;    // static pin level when test mode is off
        logic       ftest;  // 512 Hz test output enable
        logic       pos;    // 1: speed up, 0: slow down
        logic [4:0] mag;    // correction magnitude
    } cal_t;

    // Correction applied to the current second.
    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_SHORT = 2'd1,
        ADJ_LONG  = 2'd2
    } adj_e;
endpackage

// File: rtl/rtrim_cycle.sv
// Tracks the minute position within the correction cycle and decides
// whether the first second of the minute just started is corrected.
// Assumes minute_tick arrives right after the second that closes a minute.
module rtrim_cycle
    import rtrim_pkg::*;
#(
    parameter int CYC_W = 6,
    parameter int MAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             minute_tick,
    input  logic             sec_evt,
    input  logic             pos,
    input  logic [MAG_W-1:0] mag,
    output adj_e             adj
);
    localparam int ELIG_LIM = 2**CYC_W - 2;

    logic [CYC_W-1:0] pos_q;
    logic [CYC_W-1:0] pos_nxt;
    logic [CYC_W:0]   span;
    logic             elig;

    // Eligibility of the minute about to begin.
    always_comb begin
        pos_nxt = pos_q + CYC_W'(1);
        span    = (CYC_W+1)'({mag, 1'b0});
        elig    = ({1'b0, pos_nxt} < span) && (int'(pos_nxt) < ELIG_LIM);
    end

    // Minute position and pending correction for the first second.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos_q <= '1;
            adj   <= ADJ_NONE;
        end else if (minute_tick) begin
            pos_q <= pos_nxt;
            adj   <= elig ? (pos ? ADJ_SHORT : ADJ_LONG) : ADJ_NONE;
        end else if (sec_evt) begin
            adj   <= ADJ_NONE;
        end
    end
endmodule

// File: rtl/rtrim_div.sv
// Two-stage divider: a low stage of 2**LO_W enables and a high stage of
// 2**HI_W low periods. A long second stretches its first low period by
// EXTRA_CYC; a short second ends DROP_PER low periods early.
module rtrim_div
    import rtrim_pkg::*;
#(
    parameter int LO_W      = 8,
    parameter int HI_W      = 7,
    parameter int EXTRA_CYC = 128,
    parameter int DROP_PER  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  adj_e adj,
    output logic sec_evt,
    output logic sec_q
);
    localparam int LO_LEN = 2**LO_W;
    localparam int LO_CW  = $clog2(LO_LEN + EXTRA_CYC + 1);
    localparam logic [LO_CW-1:0] LO_NORM  = LO_CW'(LO_LEN - 1);
    localparam logic [LO_CW-1:0] LO_LONG  = LO_CW'(LO_LEN + EXTRA_CYC - 1);
    localparam logic [HI_W-1:0]  HI_NORM  = HI_W'(2**HI_W - 1);
    localparam logic [HI_W-1:0]  HI_SHORT = HI_W'(2**HI_W - 1 - DROP_PER);

    logic [LO_CW-1:0] lo;
    logic [HI_W-1:0]  hi;
    logic [LO_CW-1:0] lo_last;
    logic [HI_W-1:0]  hi_last;
    logic             per_evt;

    // Terminal counts for the current period and second.
    always_comb begin
        lo_last = (adj == ADJ_LONG && hi == '0) ? LO_LONG : LO_NORM;
        hi_last = (adj == ADJ_SHORT) ? HI_SHORT : HI_NORM;
        per_evt = run && (lo >= lo_last);
        sec_evt = per_evt && (hi >= hi_last);
    end

    // Divider stages and registered second pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lo    <= '0;
            hi    <= '0;
            sec_q <= 1'b0;
        end else begin
            sec_q <= sec_evt;
            if (run) begin
                if (per_evt) begin
                    lo <= '0;
                    hi <= sec_evt ? '0 : hi + HI_W'(1);
                end else begin
                    lo <= lo + LO_CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/rtrim_ftest.sv
// Free-running test toggle: flips every HALF counted enables. It is kept
// apart from the divider so that trimming never moves its edges.
module rtrim_ftest #(
    parameter int HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tog
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    // Half-period counter and toggle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            tog <= 1'b0;
        end else if (run) begin
            if (cnt == CW'(HALF - 1)) begin
                cnt <= '0;
                tog <= ~tog;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/rtrim_unit.sv
// Rate-trim second generator with open-drain test/level output.
// Assumes osc_en is a one-cycle enable per oscillator period and that
// minute_tick follows the second pulse that closes each minute.
module rtrim_unit
    import rtrim_pkg::*;
#(
    parameter int LO_W      = 8,
    parameter int HI_W      = 7,
    parameter int EXTRA_CYC = 128,
    parameter int DROP_PER  = 1,
    parameter int CYC_W     = 6,
    parameter int TEST_HALF = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       stop,
    input  logic       clr,
    input  logic       minute_tick,
    input  logic [7:0] cal,
    output logic       sec_tick,
    output logic       pin_low
);
    cal_t cal_s;
    adj_e adj;
    logic run;
    logic sec_evt;
    logic tog;

    // Field view of the control byte and counting enable.
    always_comb begin
        cal_s = cal_t'(cal);
        run   = osc_en && !stop;
    end

    rtrim_cycle #(.CYC_W(CYC_W), .MAG_W(5)) u_cycle (
        .clk(clk), .rst_n(rst_n), .clr(clr), .minute_tick(minute_tick),
        .sec_evt(sec_evt), .pos(cal_s.pos), .mag(cal_s.mag), .adj(adj)
    );

    rtrim_div #(
        .LO_W(LO_W), .HI_W(HI_W), .EXTRA_CYC(EXTRA_CYC), .DROP_PER(DROP_PER)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .adj(adj),
        .sec_evt(sec_evt), .sec_q(sec_tick)
    );

    rtrim_ftest #(.HALF(TEST_HALF)) u_ftest (
        .clk(clk), .rst_n(rst_n), .run(run), .tog(tog)
    );

    // Pin mux: test toggle or static level; 1 pulls the line low.
    always_comb begin
        pin_low = cal_s.ftest ? ~tog : ~cal_s.lvl;
    end
endmodule

// File: rtl/rtrim_unit_chk.sv
// Port-level properties of the rate-trim unit, bound to every instance.
module rtrim_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_en,
    input logic       stop,
    input logic       clr,
    input logic [7:0] cal,
    input logic       sec_tick,
    input logic       pin_low
);
    // R1: second pulse lasts one cycle.
    p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R2: an uncounted cycle cannot produce a second.
    p_idle_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en || stop) |=> !sec_tick);

    // R2: the test toggle holds while counting is halted.
    p_frozen_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cal[6] && (!osc_en || stop)) |=> (!cal[6] || $stable(pin_low)));

    // R7: clear suppresses the next second pulse.
    p_clear_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !sec_tick);

    // R9: level mode shows the inverted level bit.
    p_level_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cal[6] |-> (pin_low == !cal[7]));
endmodule

bind rtrim_unit rtrim_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop), .clr(clr),
    .cal(cal), .sec_tick(sec_tick), .pin_low(pin_low)
);

// File: tb/tb_rtrim_unit.sv
`timescale 1ns/1ps
module tb_rtrim_unit;
    localparam int NORM  = 1024;   // 2**(8+2) with HI_W = 2
    localparam int SHORT = 768;
    localparam int LONG  = 1152;

    typedef struct packed {
        logic [7:0]  cal;
        logic [7:0]  nmin;
        logic [7:0]  nmod;
        logic [15:0] mlen;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'h00, 8'd4,  8'd0,  16'd1024},
        '{8'h21, 8'd5,  8'd2,  16'd768},
        '{8'h06, 8'd14, 8'd12, 16'd1152},
        '{8'h3F, 8'd66, 8'd64, 16'd768},
        '{8'hDF, 8'd4,  8'd4,  16'd1152}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_en = 1'b1;
    logic stop = 1'b0;
    logic clr = 1'b0;
    logic minute_tick = 1'b0;
    logic [7:0] cal = 8'h40;
    logic sec_tick;
    logic pin_low;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtrim_unit #(.HI_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop), .clr(clr),
        .minute_tick(minute_tick), .cal(cal), .sec_tick(sec_tick),
        .pin_low(pin_low)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Count negedges until the next second pulse; optionally open a minute.
    task automatic run_sec(input bit min_after, output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
            minute_tick = 1'b0;
        end while (!sec_tick);
        if (min_after) minute_tick = 1'b1;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        minute_tick = 1'b0;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Cycles between two consecutive pin changes, with optional clr inside.
    task automatic pin_spacing(input bit with_clr, output int sp);
        logic prev;
        prev = pin_low;
        do @(negedge clk); while (pin_low == prev);
        prev = pin_low;
        sp = 0;
        do begin
            @(negedge clk);
            sp++;
            if (with_clr) clr = (sp == 10);
        end while (pin_low == prev);
        clr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual %0d cycles expected fewer", 190000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int len;
        int sp;
        int nchg;
        logic prev;

        // R10: state during reset.
        repeat (4) @(negedge clk);
        chk("R10", "sec_tick in reset", int'(sec_tick), 0);
        chk("R10", "pin_low in reset with test on", int'(pin_low), 1);

        // R10: counting from zero, cycle position as after clear.
        cal = 8'h21;
        rst_n = 1'b1;
        run_sec(1'b1, len);
        chk("R10", "first second after reset", len, NORM);
        run_sec(1'b0, len);
        chk("R10", "minute 0 after reset corrected", len, SHORT);

        // Vector table: R3 R4 R5 R6 R7.
        foreach (VECS[i]) begin
            int nmod;
            int n;
            bit pos;
            cal = VECS[i].cal;
            n = int'(VECS[i].cal[4:0]);
            pos = VECS[i].cal[5];
            nmod = 0;
            pulse_clr();
            run_sec(1'b1, len);
            chk("R7", "plain second after clear", len, NORM);
            for (int k = 0; k < int'(VECS[i].nmin); k++) begin
                int idx;
                bit md;
                int exp;
                string req;
                idx = k % 64;
                md = (n > 0) && (idx < 2 * n);
                exp = md ? (pos ? SHORT : LONG) : NORM;
                req = (k >= 64) ? "R6" : (md ? (pos ? "R3" : "R4") : "R5");
                run_sec(1'b1, len);
                chk(req, $sformatf("vec %0d minute %0d length", i, k), len, exp);
                if (len != NORM) begin
                    nmod++;
                    chk(pos ? "R3" : "R4", "corrected length", len, int'(VECS[i].mlen));
                end
            end
            chk("R5", $sformatf("vec %0d corrected count", i), nmod, int'(VECS[i].nmod));
        end

        // R2: stop and missing enables freeze divider and test toggle.
        cal = 8'h40;
        pulse_clr();
        len = 0;
        repeat (100) begin @(negedge clk); len++; end
        stop = 1'b1;
        prev = pin_low;
        nchg = 0;
        repeat (40) begin
            @(negedge clk); len++;
            if (pin_low != prev) nchg++;
        end
        stop = 1'b0;
        osc_en = 1'b0;
        repeat (30) begin
            @(negedge clk); len++;
            if (pin_low != prev) nchg++;
        end
        osc_en = 1'b1;
        chk("R2", "test pin changes while halted", nchg, 0);
        run_sec(1'b0, sp);
        chk("R2", "second with 70 halted cycles", len + sp, NORM + 70);

        // R8: test toggle spacing, independent of trim and clear.
        pin_spacing(1'b0, sp);
        chk("R8", "toggle spacing", sp, 32);
        cal = 8'h7F;
        pin_spacing(1'b0, sp);
        chk("R8", "toggle spacing with trim set", sp, 32);
        pin_spacing(1'b1, sp);
        chk("R8", "toggle spacing across clear", sp, 32);

        // R9: level mode.
        cal = 8'h80;
        @(negedge clk);
        chk("R9", "level 1 releases pin", int'(pin_low), 0);
        cal = 8'h00;
        @(negedge clk);
        chk("R9", "level 0 pulls pin", int'(pin_low), 1);
        cal = 8'hBF;
        @(negedge clk);
        chk("R9", "level 1 with trim bits set", int'(pin_low), 0);

        // R7 and R1: clear mid-second restarts; pulse is one cycle.
        cal = 8'h00;
        repeat (300) @(negedge clk);
        pulse_clr();
        run_sec(1'b0, len);
        chk("R7", "second after mid clear", len, NORM);
        @(negedge clk);
        chk("R1", "pulse one cycle wide", int'(sec_tick), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule